// File: doc/BRIEF.md
# Reservation Station with Broadcast Wakeup

This block is a small pool of reservation slots that sits in front of a single functional unit in an out-of-order core. The issue stage presents one instruction per cycle: an operation code, two source operands, a destination tag and a mask of the unresolved branches that precede it. A source operand whose producer tag is zero already carries its value. Any other tag names the in-flight instruction that will produce the value. The instruction goes into the lowest-numbered free slot. When every slot is occupied, the issue stage is told to hold.

Every slot watches one common result bus. When a valid result whose tag matches a waiting operand appears, the slot copies the data and stops waiting. A slot becomes eligible once both operands hold values and no earlier branch is still open. Each cycle, the oldest eligible slot is sent to the functional unit and freed. A branch outcome port either removes one branch from every slot's mask (correct prediction) or discards every slot that depends on that branch (misprediction).

Top module: `rs_station`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `dsp_valid` is 0 and `iss_stall` is 0.
- R2: An issue with `iss_valid` high and `iss_stall` low is stored. `iss_stall` is high exactly when all NUM_SLOTS slots are occupied, and an issue presented while stalled is dropped.
- R3: A source tag of 0 means the value is present. The accompanying value is stored and needs no wakeup.
- R4: When `res_valid` is high, every stored operand waiting on a nonzero tag equal to `res_tag` takes `res_data` and stops waiting. The capture counts for eligibility from the following cycle.
- R5: When an issue names a nonzero source tag that equals `res_tag` of a valid result in the same cycle, the new slot stores `res_data` for that operand as already present.
- R6: A slot is eligible only when both operands hold values and its branch mask is zero. At most one slot dispatches per cycle, and it drives its op, both operand values and its destination tag on the dispatch outputs, with `dsp_valid` high, combinationally from stored state.
- R7: When several slots are eligible, the one issued earliest dispatches first.
- R8: Bit b of `iss_br_mask` marks dependence on open branch b. A slot with any mask bit set never dispatches. `br_valid` with `br_mispredict` low clears bit `br_id` in every stored slot and in an issue accepted in the same cycle.
- R9: `br_valid` with `br_mispredict` high discards every stored slot, and an issue accepted in the same cycle, whose mask has bit `br_id` set. Discarded entries never dispatch, and all other slots are unaffected.
- R10: A slot is freed at the clock edge that ends its dispatch cycle, so a full station accepts an issue in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | Issue request |
| iss_op | input | OP_W | Operation code |
| iss_src1_tag | input | TAG_W | First operand producer tag, 0 = value present |
| iss_src1_val | input | DATA_W | First operand value |
| iss_src2_tag | input | TAG_W | Second operand producer tag, 0 = value present |
| iss_src2_val | input | DATA_W | Second operand value |
| iss_dst_tag | input | TAG_W | Destination tag |
| iss_br_mask | input | BR_N | Open earlier branches |
| iss_stall | output | 1 | All slots occupied, issue is not taken |
| res_valid | input | 1 | Result bus valid |
| res_tag | input | TAG_W | Result bus producer tag |
| res_data | input | DATA_W | Result bus value |
| br_valid | input | 1 | Branch outcome valid |
| br_id | input | BRID_W | Branch index |
| br_mispredict | input | 1 | 1 = discard dependents, 0 = release |
| dsp_valid | output | 1 | Dispatch to functional unit |
| dsp_op | output | OP_W | Dispatched operation |
| dsp_a | output | DATA_W | First operand value |
| dsp_b | output | DATA_W | Second operand value |
| dsp_dst | output | TAG_W | Dispatched destination tag |

## Verification
The assertions assume the result bus never carries tag 0. They also assume that a `br_id` names a branch which is actually open, so that a mask bit is never set after its branch has resolved. The bench draws result tags only from 1 to 15. It keeps a set of open branch indices, builds every issue mask from that set, and resolves or flushes only indices in that set before returning them for reuse. Random results are offered every other cycle on average, so waiting operands drain and the random phase fills and empties the station many times.

// File: rtl/rs_pkg.sv
package rs_pkg;

    parameter int RS_ENTRIES = 4;
    parameter int TAG_W      = 4;
    parameter int DATA_W     = 16;
    parameter int OP_W       = 4;
    parameter int BR_N       = 4;

    localparam int BRID_W = (BR_N > 1) ? $clog2(BR_N) : 1;

    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [DATA_W-1:0] data_t;
    typedef logic [OP_W-1:0]   op_t;
    typedef logic [BR_N-1:0]   brmask_t;
    typedef logic [BRID_W-1:0] brid_t;

    // Contents of one slot apart from its occupancy and age.
    typedef struct packed {
        op_t     op;
        tag_t    src1_tag;
        data_t   src1_val;
        tag_t    src2_tag;
        data_t   src2_val;
        tag_t    dst;
        brmask_t brmask;
    } rs_body_t;

    // A waiting operand matches a valid broadcast with the same nonzero tag.
    function automatic logic tag_hit(tag_t wait_tag, logic bus_v, tag_t bus_tag);
        return bus_v && (wait_tag != '0) && (wait_tag == bus_tag);
    endfunction

    function automatic brmask_t br_bit(brid_t id);
        brmask_t m;
        m = '0;
        m[id] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/rs_slot.sv
module rs_slot
    import rs_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     alloc,
    input  rs_body_t alloc_body,
    input  logic     res_valid,
    input  tag_t     res_tag,
    input  data_t    res_data,
    input  logic     br_valid,
    input  brid_t    br_id,
    input  logic     br_mispredict,
    input  logic     grant,
    output logic     busy,
    output rs_body_t body,
    output logic     ready,
    output logic     killed
);

    logic     flush;
    logic     release_br;
    brmask_t  clr_mask;
    logic     busy_nx;
    rs_body_t body_nx;

    assign flush      = br_valid && br_mispredict;
    assign release_br = br_valid && !br_mispredict;
    assign clr_mask   = release_br ? br_bit(br_id) : '0;

    assign killed = busy && flush && body.brmask[br_id];
    assign ready  = busy && (body.src1_tag == '0) && (body.src2_tag == '0)
                    && (body.brmask == '0);

    always_comb begin
        body_nx = body;
        busy_nx = busy && !grant && !killed;
        if (alloc) begin
            body_nx        = alloc_body;
            body_nx.brmask = alloc_body.brmask & ~clr_mask;
            busy_nx        = !(flush && alloc_body.brmask[br_id]);
        end else begin
            if (tag_hit(body.src1_tag, res_valid, res_tag)) begin
                body_nx.src1_tag = '0;
                body_nx.src1_val = res_data;
            end
            if (tag_hit(body.src2_tag, res_valid, res_tag)) begin
                body_nx.src2_tag = '0;
                body_nx.src2_val = res_data;
            end
            body_nx.brmask = body.brmask & ~clr_mask;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            body <= '0;
        end else begin
            busy <= busy_nx;
            body <= body_nx;
        end
    end

    assert_alloc_free_R2: assert property (@(posedge clk) disable iff (rst)
        alloc |-> !busy);

    assert_wake_src1_R4: assert property (@(posedge clk) disable iff (rst)
        (busy && !alloc && !killed && tag_hit(body.src1_tag, res_valid, res_tag))
        |=> (busy && body.src1_tag == '0 && body.src1_val == $past(res_data)));

    assert_wake_src2_R4: assert property (@(posedge clk) disable iff (rst)
        (busy && !alloc && !killed && tag_hit(body.src2_tag, res_valid, res_tag))
        |=> (busy && body.src2_tag == '0 && body.src2_val == $past(res_data)));

    assert_grant_ready_R6: assert property (@(posedge clk) disable iff (rst)
        grant |-> (busy && body.src1_tag == '0 && body.src2_tag == '0));

    assert_branch_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && body.brmask != '0) |-> !grant);

    assert_flush_drop_R9: assert property (@(posedge clk) disable iff (rst)
        killed |=> !busy);

endmodule

// File: rtl/rs_age.sv
module rs_age
    import rs_pkg::*;
#(
    parameter int N = RS_ENTRIES
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic [N-1:0]                     busy,
    input  logic [N-1:0]                     alloc,
    input  logic [N-1:0]                     leave,
    input  logic                             new_kept,
    output logic [N-1:0][((N>1)?$clog2(N):1)-1:0] age
);

    localparam int AW = (N > 1) ? $clog2(N) : 1;

    // age = number of occupied slots younger than this one.
    logic [N-1:0][AW-1:0] age_nx;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            int drop;
            drop = 0;
            for (int j = 0; j < N; j++) begin
                if (leave[j] && busy[j] && (age[j] < age[i])) drop++;
            end
            if (alloc[i]) age_nx[i] = '0;
            else          age_nx[i] = AW'(int'(age[i]) - drop + int'(new_kept));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) age <= '0;
        else     age <= age_nx;
    end

    for (genvar gi = 0; gi < N; gi++) begin : g_row
        for (genvar gj = gi + 1; gj < N; gj++) begin : g_col
            assert_age_unique_R7: assert property (@(posedge clk) disable iff (rst)
                (busy[gi] && busy[gj]) |-> (age[gi] != age[gj]));
        end
    end

endmodule

// File: rtl/rs_oldest_pick.sv
module rs_oldest_pick
    import rs_pkg::*;
#(
    parameter int N = RS_ENTRIES
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic [N-1:0]                     req,
    input  logic [N-1:0][((N>1)?$clog2(N):1)-1:0] age,
    output logic [N-1:0]                     grant,
    output logic [((N>1)?$clog2(N):1)-1:0]   idx,
    output logic                             found
);

    localparam int AW = (N > 1) ? $clog2(N) : 1;

    logic [AW-1:0] best;

    always_comb begin
        found = 1'b0;
        best  = '0;
        idx   = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && (!found || age[i] > best)) begin
                found = 1'b1;
                best  = age[i];
                idx   = AW'(i);
            end
        end
        grant = '0;
        if (found) grant[idx] = 1'b1;
    end

    assert_one_grant_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    for (genvar gi = 0; gi < N; gi++) begin : g_win
        for (genvar gj = 0; gj < N; gj++) begin : g_other
            if (gi != gj) begin : g_pair
                assert_oldest_first_R7: assert property (@(posedge clk) disable iff (rst)
                    (grant[gi] && req[gj]) |-> (age[gj] < age[gi]));
            end
        end
    end

endmodule

// File: rtl/rs_station.sv
module rs_station
    import rs_pkg::*;
#(
    parameter int NUM_SLOTS = RS_ENTRIES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              iss_valid,
    input  logic [OP_W-1:0]   iss_op,
    input  logic [TAG_W-1:0]  iss_src1_tag,
    input  logic [DATA_W-1:0] iss_src1_val,
    input  logic [TAG_W-1:0]  iss_src2_tag,
    input  logic [DATA_W-1:0] iss_src2_val,
    input  logic [TAG_W-1:0]  iss_dst_tag,
    input  logic [BR_N-1:0]   iss_br_mask,
    output logic              iss_stall,
    input  logic              res_valid,
    input  logic [TAG_W-1:0]  res_tag,
    input  logic [DATA_W-1:0] res_data,
    input  logic              br_valid,
    input  logic [BRID_W-1:0] br_id,
    input  logic              br_mispredict,
    output logic              dsp_valid,
    output logic [OP_W-1:0]   dsp_op,
    output logic [DATA_W-1:0] dsp_a,
    output logic [DATA_W-1:0] dsp_b,
    output logic [TAG_W-1:0]  dsp_dst
);

    localparam int AW = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

    logic [NUM_SLOTS-1:0]         busy;
    logic [NUM_SLOTS-1:0]         ready;
    logic [NUM_SLOTS-1:0]         killed;
    logic [NUM_SLOTS-1:0]         grant;
    logic [NUM_SLOTS-1:0]         alloc_vec;
    logic [NUM_SLOTS-1:0]         leave;
    logic [NUM_SLOTS-1:0][AW-1:0] age;
    rs_body_t                     body [NUM_SLOTS];
    rs_body_t                     new_body;
    rs_body_t                     sel;
    logic [AW-1:0]                free_idx;
    logic                         free_found;
    logic [AW-1:0]                pick_idx;
    logic                         pick_found;
    logic                         alloc_go;
    logic                         new_kept;

    // Lowest-numbered free slot takes the next issue.
    always_comb begin
        free_found = 1'b0;
        free_idx   = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (!busy[i] && !free_found) begin
                free_found = 1'b1;
                free_idx   = AW'(i);
            end
        end
    end

    assign iss_stall = !free_found;
    assign alloc_go  = iss_valid && free_found;

    always_comb begin
        alloc_vec = '0;
        if (alloc_go) alloc_vec[free_idx] = 1'b1;
    end

    // Operand capture at issue, including a same-cycle broadcast.
    always_comb begin
        new_body.op       = iss_op;
        new_body.dst      = iss_dst_tag;
        new_body.brmask   = iss_br_mask;
        new_body.src1_tag = iss_src1_tag;
        new_body.src1_val = iss_src1_val;
        new_body.src2_tag = iss_src2_tag;
        new_body.src2_val = iss_src2_val;
        if (tag_hit(iss_src1_tag, res_valid, res_tag)) begin
            new_body.src1_tag = '0;
            new_body.src1_val = res_data;
        end
        if (tag_hit(iss_src2_tag, res_valid, res_tag)) begin
            new_body.src2_tag = '0;
            new_body.src2_val = res_data;
        end
    end

    assign new_kept = alloc_go && !(br_valid && br_mispredict && iss_br_mask[br_id]);
    assign leave    = grant | killed;

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        rs_slot u_slot (
            .clk          (clk),
            .rst          (rst),
            .alloc        (alloc_vec[g]),
            .alloc_body   (new_body),
            .res_valid    (res_valid),
            .res_tag      (res_tag),
            .res_data     (res_data),
            .br_valid     (br_valid),
            .br_id        (br_id),
            .br_mispredict(br_mispredict),
            .grant        (grant[g]),
            .busy         (busy[g]),
            .body         (body[g]),
            .ready        (ready[g]),
            .killed       (killed[g])
        );
    end

    rs_age #(.N(NUM_SLOTS)) u_age (
        .clk     (clk),
        .rst     (rst),
        .busy    (busy),
        .alloc   (alloc_vec),
        .leave   (leave),
        .new_kept(new_kept),
        .age     (age)
    );

    rs_oldest_pick #(.N(NUM_SLOTS)) u_pick (
        .clk  (clk),
        .rst  (rst),
        .req  (ready),
        .age  (age),
        .grant(grant),
        .idx  (pick_idx),
        .found(pick_found)
    );

    assign sel       = body[pick_idx];
    assign dsp_valid = pick_found;
    assign dsp_op    = sel.op;
    assign dsp_a     = sel.src1_val;
    assign dsp_b     = sel.src2_val;
    assign dsp_dst   = sel.dst;

    assert_stall_blocks_R2: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && iss_stall) |=> ($countones(busy) <= $past($countones(busy))));

    assert_freed_on_dispatch_R10: assert property (@(posedge clk) disable iff (rst)
        (dsp_valid && iss_stall) |=> !iss_stall);

    assert_bypass_src1_R5: assert property (@(posedge clk) disable iff (rst)
        (alloc_go && new_kept && tag_hit(iss_src1_tag, res_valid, res_tag))
        |=> (busy[$past(free_idx)] && body[$past(free_idx)].src1_tag == '0
             && body[$past(free_idx)].src1_val == $past(res_data)));

endmodule

// File: tb/rs_station_tb.sv
module rs_station_tb;
    import rs_pkg::*;

    localparam int N = RS_ENTRIES;

    logic              clk = 1'b0;
    logic              rst;
    logic              iss_valid;
    logic [OP_W-1:0]   iss_op;
    logic [TAG_W-1:0]  iss_src1_tag, iss_src2_tag, iss_dst_tag;
    logic [DATA_W-1:0] iss_src1_val, iss_src2_val;
    logic [BR_N-1:0]   iss_br_mask;
    logic              iss_stall;
    logic              res_valid;
    logic [TAG_W-1:0]  res_tag;
    logic [DATA_W-1:0] res_data;
    logic              br_valid;
    logic [BRID_W-1:0] br_id;
    logic              br_mispredict;
    logic              dsp_valid;
    logic [OP_W-1:0]   dsp_op;
    logic [DATA_W-1:0] dsp_a, dsp_b;
    logic [TAG_W-1:0]  dsp_dst;

    always #10 clk = ~clk;

    rs_station u_dut (
        .clk(clk), .rst(rst),
        .iss_valid(iss_valid), .iss_op(iss_op),
        .iss_src1_tag(iss_src1_tag), .iss_src1_val(iss_src1_val),
        .iss_src2_tag(iss_src2_tag), .iss_src2_val(iss_src2_val),
        .iss_dst_tag(iss_dst_tag), .iss_br_mask(iss_br_mask),
        .iss_stall(iss_stall),
        .res_valid(res_valid), .res_tag(res_tag), .res_data(res_data),
        .br_valid(br_valid), .br_id(br_id), .br_mispredict(br_mispredict),
        .dsp_valid(dsp_valid), .dsp_op(dsp_op), .dsp_a(dsp_a),
        .dsp_b(dsp_b), .dsp_dst(dsp_dst)
    );

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 0;

    // Reference model of the requirements.
    bit      m_busy [N];
    int      m_seq  [N];
    op_t     m_op   [N];
    tag_t    m_qj   [N], m_qk [N], m_dst [N];
    data_t   m_vj   [N], m_vk [N];
    brmask_t m_mask [N];
    int      seq_ctr = 0;
    brmask_t open_br = '0;

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic bit model_full();
        for (int i = 0; i < N; i++) if (!m_busy[i]) return 1'b0;
        return 1'b1;
    endfunction

    function automatic int model_pick();
        int best;
        best = -1;
        for (int i = 0; i < N; i++) begin
            if (m_busy[i] && m_qj[i] == 0 && m_qk[i] == 0 && m_mask[i] == 0)
                if (best < 0 || m_seq[i] < m_seq[best]) best = i;
        end
        return best;
    endfunction

    function automatic bit hit(tag_t w);
        return res_valid && w != 0 && w == res_tag;
    endfunction

    task automatic model_step(int e, bit was_full);
        bit flush, rel;
        flush = br_valid && br_mispredict;
        rel   = br_valid && !br_mispredict;
        if (e >= 0) m_busy[e] = 0;
        for (int i = 0; i < N; i++) begin
            if (m_busy[i]) begin
                if (flush && m_mask[i][br_id]) m_busy[i] = 0;
                else begin
                    if (rel) m_mask[i][br_id] = 1'b0;
                    if (hit(m_qj[i])) begin m_vj[i] = res_data; m_qj[i] = 0; end
                    if (hit(m_qk[i])) begin m_vk[i] = res_data; m_qk[i] = 0; end
                end
            end
        end
        if (iss_valid && !was_full && !(flush && iss_br_mask[br_id])) begin
            for (int i = 0; i < N; i++) begin
                if (!m_busy[i]) begin
                    m_busy[i] = 1; m_seq[i] = seq_ctr++;
                    m_op[i] = iss_op; m_dst[i] = iss_dst_tag;
                    m_qj[i] = iss_src1_tag; m_vj[i] = iss_src1_val;
                    m_qk[i] = iss_src2_tag; m_vk[i] = iss_src2_val;
                    if (hit(iss_src1_tag)) begin m_qj[i] = 0; m_vj[i] = res_data; end
                    if (hit(iss_src2_tag)) begin m_qk[i] = 0; m_vk[i] = res_data; end
                    m_mask[i] = iss_br_mask;
                    if (rel) m_mask[i][br_id] = 1'b0;
                    break;
                end
            end
        end
    endtask

    // Inputs are set at a falling edge; compare, model the next edge, move on.
    task automatic run_cycle(string req);
        int e;
        bit f;
        #1;
        e = model_pick();
        f = model_full();
        chk(req, "iss_stall", iss_stall, f);
        chk(req, "dsp_valid", dsp_valid, e >= 0);
        if (e >= 0) begin
            chk(req, "dsp_op", dsp_op, m_op[e]);
            chk(req, "dsp_a", dsp_a, m_vj[e]);
            chk(req, "dsp_b", dsp_b, m_vk[e]);
            chk(req, "dsp_dst", dsp_dst, m_dst[e]);
        end
        model_step(e, f);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        iss_valid = 0; iss_op = 0; iss_src1_tag = 0; iss_src1_val = 0;
        iss_src2_tag = 0; iss_src2_val = 0; iss_dst_tag = 0; iss_br_mask = 0;
        res_valid = 0; res_tag = 0; res_data = 0;
        br_valid = 0; br_id = 0; br_mispredict = 0;
    endtask

    task automatic put_issue(op_t op, tag_t t1, data_t v1, tag_t t2, data_t v2,
                             tag_t d, brmask_t m);
        iss_valid = 1; iss_op = op; iss_src1_tag = t1; iss_src1_val = v1;
        iss_src2_tag = t2; iss_src2_val = v2; iss_dst_tag = d; iss_br_mask = m;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h00C0FFEE));
        idle_inputs();
        rst = 1;
        for (int i = 0; i < N; i++) m_busy[i] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "dsp_valid in reset", dsp_valid, 0);
        chk("R1", "iss_stall in reset", iss_stall, 0);
        rst = 0;
        run_cycle("R1");

        // R2: fill with waiting entries, then a dropped issue while full.
        for (int k = 0; k < N; k++) begin
            put_issue(op_t'(k + 1), 4'd5, 0, 0, data_t'(16'h100 + k), tag_t'(k + 1), 0);
            run_cycle("R2");
        end
        put_issue(4'hF, 0, 16'hDEAD, 0, 16'hBEEF, 4'hE, 0);
        run_cycle("R2");
        chk("R2", "stall while full", iss_stall, 1);
        // R4: one broadcast wakes every waiter; R7 oldest first; R10 slot reuse.
        idle_inputs();
        res_valid = 1; res_tag = 4'd5; res_data = 16'h5A5A;
        run_cycle("R4");
        idle_inputs();
        run_cycle("R7");
        chk("R10", "stall after dispatch", iss_stall, 0);
        put_issue(4'h9, 0, 16'h0009, 0, 16'h0090, 4'h9, 0);
        run_cycle("R10");
        for (int k = 0; k < N + 1; k++) begin
            idle_inputs();
            run_cycle("R7");
        end

        // R3: values present at issue.
        put_issue(4'h3, 0, 16'h1234, 0, 16'h4321, 4'h3, 0);
        run_cycle("R3");
        idle_inputs();
        chk("R3", "immediate dispatch", dsp_valid, 1);
        run_cycle("R3");

        // R5: same-cycle broadcast captured by the new entry.
        put_issue(4'h5, 4'd7, 16'h0000, 0, 16'h0055, 4'h6, 0);
        res_valid = 1; res_tag = 4'd7; res_data = 16'hABCD;
        run_cycle("R5");
        idle_inputs();
        chk("R5", "bypassed operand", dsp_a, 16'hABCD);
        run_cycle("R5");

        // R8: held behind an open branch until released.
        put_issue(4'h8, 0, 16'h0808, 0, 16'h8080, 4'h8, 4'b0001);
        run_cycle("R8");
        idle_inputs();
        run_cycle("R8");
        br_valid = 1; br_id = 0; br_mispredict = 0;
        run_cycle("R8");
        idle_inputs();
        chk("R8", "released", dsp_valid, 1);
        run_cycle("R8");

        // R9: flush removes the dependent entry only.
        put_issue(4'h1, 4'd9, 0, 0, 16'h0001, 4'h1, 4'b0000);
        run_cycle("R9");
        put_issue(4'h2, 0, 16'h0002, 0, 16'h0020, 4'h2, 4'b0010);
        run_cycle("R9");
        idle_inputs();
        br_valid = 1; br_id = 1; br_mispredict = 1;
        run_cycle("R9");
        idle_inputs();
        res_valid = 1; res_tag = 4'd9; res_data = 16'h9999;
        run_cycle("R9");
        idle_inputs();
        chk("R9", "survivor dispatched", dsp_dst, 4'h1);
        run_cycle("R9");
        chk("R9", "flushed entry gone", dsp_valid, 0);
        run_cycle("R9");

        // R6: random mixed traffic against the model.
        for (int c = 0; c < 4000; c++) begin
            brmask_t newly;
            idle_inputs();
            newly = '0;
            if ($urandom % 3 != 0) begin
                put_issue(op_t'($urandom),
                          ($urandom % 2) ? tag_t'(1 + $urandom % 15) : tag_t'(0),
                          data_t'($urandom),
                          ($urandom % 2) ? tag_t'(1 + $urandom % 15) : tag_t'(0),
                          data_t'($urandom),
                          tag_t'(1 + $urandom % 15), open_br);
            end
            if ($urandom % 2) begin
                res_valid = 1; res_tag = tag_t'(1 + $urandom % 15); res_data = data_t'($urandom);
            end
            if (open_br != 0 && $urandom % 4 == 0) begin
                for (int b = 0; b < BR_N; b++) begin
                    if (open_br[b]) begin
                        br_valid = 1; br_id = brid_t'(b);
                        br_mispredict = ($urandom % 3 == 0);
                        break;
                    end
                end
            end
            if ($urandom % 5 == 0) begin
                for (int b = BR_N - 1; b >= 0; b--) begin
                    if (!open_br[b] && !(br_valid && br_id == brid_t'(b))) begin
                        newly[b] = 1'b1;
                        break;
                    end
                end
            end
            run_cycle("R6");
            if (br_valid) open_br[br_id] = 1'b0;
            open_br = open_br | newly;
        end

        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule